// File: doc/BRIEF.md
# Host Port Slave with Half-Word Register Access

This block lets an external 16-bit host reach a 32-bit internal memory through three registers: a control register, an address register and a data register. The host qualifies each access with a chip select and a pair of data strobes. The block combines these three pins into one active-low access strobe. A two-bit register select, a read/write line and a half-word select describe the access. These select lines come either from the pins at the strobe fall or, when the optional address strobe falls first, from a copy latched at that earlier edge.

Data-register traffic moves whole 32-bit words over a request/acknowledge memory port. A read fetches a word when its low half is requested. A write is issued once its high half has arrived. The auto-increment select advances the address by one word and prefetches the next word after each high-half read. A busy line tells the host to keep its strobe low or to wait before the next access. The busy line is forced idle whenever the chip is deselected. All host inputs are asynchronous. They pass through synchronizers, and every internal change happens on the CPU clock.

Top module: `host_port_slave`

## Requirements
- R1: An access strobe is active only while `host_cs_n` is low and exactly one of `host_ds_a`, `host_ds_b` is low. Both low, both high, or chip select high starts no access.
- R2: `host_reg_sel` encodes 00 = control, 01 = data with auto-increment, 10 = address, 11 = data at a fixed address. `host_half_sel` = 0 picks bits 15:0 and 1 picks bits 31:16. A control or address write stores its half on the strobe rise and reads back unchanged.
- R3: `host_busy` is low whenever `host_cs_n` is high, even while an internal operation is pending.
- R4: Control and address register accesses never raise `host_busy`.
- R5: A low-half data read issues a memory read (`mem_req`=1, `mem_we`=0) at the address register on the strobe fall. `host_busy` stays high until the word is loaded, and both halves then return that word.
- R6: Data writes collect halves in the data register. A single 32-bit memory write (`mem_we`=1, data {high, low}) is issued only after the high-half strobe rise, with `host_busy` high until acknowledged. A low-half write issues nothing.
- R7: After an auto-increment data write completes, the address register has grown by 4. Fixed-address data accesses leave it unchanged.
- R8: After the strobe rise of a high-half auto-increment read, the address grows by 4 and the next word is prefetched with `host_busy` high. The next low-half data read uses the prefetched word without a new request, and `host_busy` stays low. A write to the address or data register discards the prefetch.
- R9: If `host_cs_n` falls while an internal write or prefetch is still pending, `host_busy` is high until it completes.
- R10: `host_data_oe` goes high after the strobe fall of a read and low after the strobe rise. It never goes high for a write.
- R11: When `host_as_n` falls before the strobe, the select lines latched at that fall define the access, even if the pins change afterwards.
- R12: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until a one-cycle `mem_ack`.
- R13: After reset, `host_busy`, `host_data_oe` and `mem_req` are low, and all three registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_ds_a | input | 1 | First data strobe |
| host_ds_b | input | 1 | Second data strobe |
| host_as_n | input | 1 | Optional address strobe, active low |
| host_reg_sel | input | 2 | Register select |
| host_rd_wr | input | 1 | 1 = read, 0 = write |
| host_half_sel | input | 1 | 0 = low half-word, 1 = high half-word |
| host_data_in | input | 16 | Host write data |
| host_data_out | output | 16 | Host read data |
| host_data_oe | output | 1 | Drive enable for the host data bus |
| host_busy | output | 1 | High = not ready |
| mem_req | output | 1 | Internal memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid with ack |
| mem_ack | input | 1 | One-cycle completion pulse |

## Verification
The bench targets the prefetch hit. A design that fetched anyway would raise busy on that read. A design that skipped the fetch after a write would return stale data. It checks that a low-half write alone causes no memory write, which catches a block that commits each half separately. It deselects the chip during a slow write and then reselects it, expecting busy low and then high. A block that ignored chip select, or forgot the pending work, fails one of these. It also changes the select pins after an address-strobe fall, so a block that samples the pins at the strobe returns the wrong register.

// File: rtl/host_port_pkg.sv
package host_port_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        SEL_CTRL     = 2'b00,
        SEL_DATA_INC = 2'b01,
        SEL_ADDR     = 2'b10,
        SEL_DATA_FIX = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_PREFETCH
    } xfer_state_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     is_read;
        logic     upper;
    } access_t;

    // Active-low access strobe formed from chip select and the two data strobes.
    function automatic logic strobe_active_n(input logic cs_n, input logic ds_a, input logic ds_b);
        return ~(ds_a ^ ds_b) | cs_n;
    endfunction

    // Both data-register encodings have bit 0 set.
    function automatic logic is_data(input reg_sel_e s);
        return s[0];
    endfunction

    function automatic logic [WORD_W-1:0] put_half(input logic [WORD_W-1:0] word,
                                                   input logic [HALF_W-1:0] half,
                                                   input logic upper);
        return upper ? {half, word[HALF_W-1:0]} : {word[WORD_W-1:HALF_W], half};
    endfunction

    function automatic logic [HALF_W-1:0] get_half(input logic [WORD_W-1:0] word,
                                                   input logic upper);
        return upper ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RESET_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RESET_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hps_front.sv
module hps_front
    import host_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    strobe_pin_n,
    input  logic    as_pin_n,
    input  access_t pin_acc,
    output logic    start_pulse,
    output logic    end_pulse,
    output access_t start_acc,
    output access_t hold_acc
);
    logic    strobe_s, strobe_prev;
    logic    as_s, as_prev;
    logic    as_fall, as_rise;
    logic    as_held;
    access_t as_lat;

    hps_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_strobe (
        .clk(clk), .rst(rst), .d(strobe_pin_n), .q(strobe_s)
    );

    hps_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_as (
        .clk(clk), .rst(rst), .d(as_pin_n), .q(as_s)
    );

    assign start_pulse = strobe_prev & ~strobe_s;
    assign end_pulse   = ~strobe_prev & strobe_s;
    assign as_fall     = as_prev & ~as_s;
    assign as_rise     = ~as_prev & as_s;
    assign start_acc   = as_held ? as_lat : pin_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev <= 1'b1;
            as_prev     <= 1'b1;
            as_held     <= 1'b0;
            as_lat      <= '0;
            hold_acc    <= '0;
        end else begin
            strobe_prev <= strobe_s;
            as_prev     <= as_s;
            if (end_pulse || as_rise) as_held <= 1'b0;
            if (as_fall) begin
                as_lat  <= pin_acc;
                as_held <= 1'b1;
            end
            if (start_pulse) hold_acc <= start_acc;
        end
    end

    // R1: one strobe fall yields exactly one start event
    assert_single_start_R1: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R11: an access opened after an address-strobe fall uses the latched selects
    assert_as_latch_R11: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && as_held) |=> (hold_acc == $past(as_lat)));
endmodule

// File: rtl/hps_core.sv
module hps_core
    import host_port_pkg::*;
#(
    parameter int ADDR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_pulse,
    input  logic              end_pulse,
    input  access_t           start_acc,
    input  access_t           hold_acc,
    input  logic [HALF_W-1:0] host_din,
    output logic [HALF_W-1:0] host_dout,
    output logic              host_oe,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(ADDR_STEP);

    xfer_state_e       state;
    logic [WORD_W-1:0] ctrl_q, addr_q, data_q, sel_word;
    logic              pref_ok, store_inc, oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctrl_q    <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            pref_ok   <= 1'b0;
            store_inc <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: if (mem_ack) begin
                    data_q <= mem_rdata;
                    state  <= ST_IDLE;
                end
                ST_PREFETCH: if (mem_ack) begin
                    data_q  <= mem_rdata;
                    pref_ok <= 1'b1;
                    state   <= ST_IDLE;
                end
                ST_STORE: if (mem_ack) begin
                    if (store_inc) addr_q <= addr_q + STEP;
                    state <= ST_IDLE;
                end
                default: ;
            endcase

            if (start_pulse && start_acc.is_read) begin
                oe_q <= 1'b1;
                if (is_data(start_acc.sel) && !start_acc.upper) begin
                    if (pref_ok) pref_ok <= 1'b0;
                    else         state   <= ST_FETCH;
                end
            end

            if (end_pulse) begin
                oe_q <= 1'b0;
                if (!hold_acc.is_read) begin
                    unique case (hold_acc.sel)
                        SEL_CTRL: ctrl_q <= put_half(ctrl_q, host_din, hold_acc.upper);
                        SEL_ADDR: begin
                            addr_q  <= put_half(addr_q, host_din, hold_acc.upper);
                            pref_ok <= 1'b0;
                        end
                        default: begin
                            data_q  <= put_half(data_q, host_din, hold_acc.upper);
                            pref_ok <= 1'b0;
                            if (hold_acc.upper) begin
                                state     <= ST_STORE;
                                store_inc <= (hold_acc.sel == SEL_DATA_INC);
                            end
                        end
                    endcase
                end else if (hold_acc.sel == SEL_DATA_INC && hold_acc.upper) begin
                    addr_q <= addr_q + STEP;
                    state  <= ST_PREFETCH;
                end
            end
        end
    end

    always_comb begin
        unique case (hold_acc.sel)
            SEL_CTRL: sel_word = ctrl_q;
            SEL_ADDR: sel_word = addr_q;
            default:  sel_word = data_q;
        endcase
    end

    assign host_dout = get_half(sel_word, hold_acc.upper);
    assign host_oe   = oe_q;
    assign mem_req   = (state != ST_IDLE);
    assign mem_we    = (state == ST_STORE);
    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;
    assign busy      = mem_req;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_store_issue_R6: assert property (@(posedge clk) disable iff (rst)
        (end_pulse && !hold_acc.is_read && is_data(hold_acc.sel) && hold_acc.upper) |=> (mem_req && mem_we));

    assert_no_low_store_R6: assert property (@(posedge clk) disable iff (rst)
        (end_pulse && !hold_acc.is_read && !hold_acc.upper && !mem_req) |=> !mem_req);

    assert_fetch_issue_R5: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && start_acc.is_read && is_data(start_acc.sel) && !start_acc.upper && !pref_ok)
        |=> (mem_req && !mem_we));

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && store_inc) |=> (mem_addr == $past(mem_addr) + STEP));

    assert_reg_quiet_start_R4: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && !is_data(start_acc.sel) && !mem_req) |=> !busy);

    assert_reg_quiet_end_R4: assert property (@(posedge clk) disable iff (rst)
        (end_pulse && !is_data(hold_acc.sel) && !mem_req) |=> !busy);

    assert_oe_release_R10: assert property (@(posedge clk) disable iff (rst)
        end_pulse |=> !host_oe);
endmodule

// File: rtl/host_port_slave.sv
module host_port_slave
    import host_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_n,
    input  logic              host_ds_a,
    input  logic              host_ds_b,
    input  logic              host_as_n,
    input  logic [1:0]        host_reg_sel,
    input  logic              host_rd_wr,
    input  logic              host_half_sel,
    input  logic [HALF_W-1:0] host_data_in,
    output logic [HALF_W-1:0] host_data_out,
    output logic              host_data_oe,
    output logic              host_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic    strobe_n, start_pulse, end_pulse, core_busy;
    access_t pin_acc, start_acc, hold_acc;

    assign strobe_n = strobe_active_n(host_cs_n, host_ds_a, host_ds_b);
    assign pin_acc  = '{sel: reg_sel_e'(host_reg_sel), is_read: host_rd_wr, upper: host_half_sel};

    hps_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk         (clk),
        .rst         (rst),
        .strobe_pin_n(strobe_n),
        .as_pin_n    (host_as_n),
        .pin_acc     (pin_acc),
        .start_pulse (start_pulse),
        .end_pulse   (end_pulse),
        .start_acc   (start_acc),
        .hold_acc    (hold_acc)
    );

    hps_core #(.ADDR_STEP(ADDR_STEP)) u_core (
        .clk        (clk),
        .rst        (rst),
        .start_pulse(start_pulse),
        .end_pulse  (end_pulse),
        .start_acc  (start_acc),
        .hold_acc   (hold_acc),
        .host_din   (host_data_in),
        .host_dout  (host_data_out),
        .host_oe    (host_data_oe),
        .busy       (core_busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack)
    );

    // Busy is only presented while the chip is selected (R3, R9).
    assign host_busy = core_busy & ~host_cs_n;
endmodule

// File: tb/test_host_port_slave.sv
`timescale 1ns/1ps
module test_host_port_slave;

    typedef struct packed {
        logic [1:0]  sel;
        logic        rd;
        logic        hi;
        logic [15:0] wd;
        logic [15:0] exp;
        logic        bd;
        logic        ba;
        logic [3:0]  tag;
    } vec_t;

    // sel, rd, hi, write data, expected read, busy during, busy after, requirement
    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b0, 1'b0, 16'h1234, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 control low write
        '{2'b00, 1'b0, 1'b1, 16'hBEEF, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 control high write
        '{2'b00, 1'b1, 1'b0, 16'h0000, 16'h1234, 1'b0, 1'b0, 4'd4},  // R4 control read
        '{2'b00, 1'b1, 1'b1, 16'h0000, 16'hBEEF, 1'b0, 1'b0, 4'd4},  // R4
        '{2'b10, 1'b0, 1'b0, 16'h0008, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 address low
        '{2'b10, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 address high
        '{2'b10, 1'b1, 1'b0, 16'h0000, 16'h0008, 1'b0, 1'b0, 4'd4},  // R4 address read
        '{2'b11, 1'b1, 1'b0, 16'h0000, 16'hB23C, 1'b1, 1'b0, 4'd5},  // R5 fetch word 2
        '{2'b11, 1'b1, 1'b1, 16'h0000, 16'hA25A, 1'b0, 1'b0, 4'd5},  // R5 high half, no prefetch
        '{2'b11, 1'b0, 1'b0, 16'h5555, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6 low half only
        '{2'b11, 1'b0, 1'b1, 16'h6666, 16'h0000, 1'b0, 1'b1, 4'd6},  // R6 word write
        '{2'b10, 1'b1, 1'b0, 16'h0000, 16'h0008, 1'b0, 1'b0, 4'd7},  // R7 fixed keeps address
        '{2'b01, 1'b1, 1'b0, 16'h0000, 16'h5555, 1'b1, 1'b0, 4'd5},  // R5 fetch written word
        '{2'b01, 1'b1, 1'b1, 16'h0000, 16'h6666, 1'b0, 1'b1, 4'd8},  // R8 prefetch word 3
        '{2'b01, 1'b1, 1'b0, 16'h0000, 16'hB33C, 1'b0, 1'b0, 4'd8},  // R8 prefetch hit
        '{2'b01, 1'b1, 1'b1, 16'h0000, 16'hA35A, 1'b0, 1'b1, 4'd8},  // R8 prefetch word 4
        '{2'b10, 1'b1, 1'b0, 16'h0000, 16'h0010, 1'b0, 1'b0, 4'd8},  // R8 address advanced
        '{2'b01, 1'b0, 1'b0, 16'h1111, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6
        '{2'b01, 1'b0, 1'b1, 16'h2222, 16'h0000, 1'b0, 1'b1, 4'd7},  // R7 write with step
        '{2'b10, 1'b1, 1'b0, 16'h0000, 16'h0014, 1'b0, 1'b0, 4'd7},  // R7 address stepped
        '{2'b11, 1'b1, 1'b0, 16'h0000, 16'hB53C, 1'b1, 1'b0, 4'd5}   // R5 prefetch dropped by write
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs_n = 1'b1, host_ds_a = 1'b1, host_ds_b = 1'b1, host_as_n = 1'b1;
    logic [1:0]  host_reg_sel = 2'b00;
    logic        host_rd_wr = 1'b1, host_half_sel = 1'b0;
    logic [15:0] host_data_in = '0;
    logic [15:0] host_data_out;
    logic        host_data_oe, host_busy;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [16];
    int          mem_lat = 3;
    int          lat_cnt;
    int          wr_count;
    int          total = 0, fails = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    host_port_slave i_host_port_slave (
        .clk(clk), .rst(rst),
        .host_cs_n(host_cs_n), .host_ds_a(host_ds_a), .host_ds_b(host_ds_b), .host_as_n(host_as_n),
        .host_reg_sel(host_reg_sel), .host_rd_wr(host_rd_wr), .host_half_sel(host_half_sel),
        .host_data_in(host_data_in), .host_data_out(host_data_out), .host_data_oe(host_data_oe),
        .host_busy(host_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory model: acknowledges after mem_lat cycles.
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
            wr_count  <= 0;
            for (int i = 0; i < 16; i++)
                mem[i] <= {4'hA, 4'(i), 8'h5A, 4'hB, 4'(i), 8'h3C};
        end else if (mem_req && !mem_ack) begin
            if (lat_cnt + 1 >= mem_lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[5:2]];
                if (mem_we) begin
                    mem[mem_addr[5:2]] <= mem_wdata;
                    wr_count <= wr_count + 1;
                end
                lat_cnt <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 400 && host_busy; n++) @(negedge clk);
    endtask

    task automatic host_access(input logic [1:0] sel, input logic rd, input logic hi,
                               input logic [15:0] wd, input bit use_b,
                               output logic [15:0] rdata, output bit b_during,
                               output bit b_after, output bit oe_during, output bit oe_after);
        @(negedge clk);
        host_reg_sel = sel; host_rd_wr = rd; host_half_sel = hi; host_data_in = wd;
        host_cs_n = 1'b0;
        @(negedge clk);
        if (use_b) host_ds_b = 1'b0; else host_ds_a = 1'b0;
        b_during = 0;
        repeat (5) begin
            @(negedge clk);
            if (host_busy) b_during = 1;
        end
        wait_idle();
        @(negedge clk);
        rdata = host_data_out;
        oe_during = host_data_oe;
        host_ds_a = 1'b1; host_ds_b = 1'b1;
        b_after = 0;
        repeat (6) begin
            @(negedge clk);
            if (host_busy) b_after = 1;
        end
        wait_idle();
        oe_after = host_data_oe;
        host_cs_n = 1'b1;
    endtask

    initial begin
        logic [15:0] rdv;
        logic [31:0] a0;
        bit bd, ba, oed, oea;
        string t;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        check(host_busy == 1'b0, "R13 busy", 32'(host_busy), 0);
        check(host_data_oe == 1'b0, "R13 oe", 32'(host_data_oe), 0);
        check(mem_req == 1'b0, "R13 req", 32'(mem_req), 0);
        host_access(2'b10, 1'b1, 1'b1, 16'h0, 1'b0, rdv, bd, ba, oed, oea);
        check(rdv == 16'h0, "R13 address zero", 32'(rdv), 0);

        foreach (VECS[i]) begin
            host_access(VECS[i].sel, VECS[i].rd, VECS[i].hi, VECS[i].wd, 1'b0, rdv, bd, ba, oed, oea);
            t = $sformatf("R%0d vec %0d", VECS[i].tag, i);
            check(bd == VECS[i].bd, {t, " busy during"}, 32'(bd), 32'(VECS[i].bd));
            check(ba == VECS[i].ba, {t, " busy after"}, 32'(ba), 32'(VECS[i].ba));
            check(oed == VECS[i].rd, {"R10 ", t, " oe during"}, 32'(oed), 32'(VECS[i].rd));
            check(oea == 1'b0, {"R10 ", t, " oe after"}, 32'(oea), 0);
            if (VECS[i].rd)
                check(rdv == VECS[i].exp, {t, " data"}, 32'(rdv), 32'(VECS[i].exp));
        end

        // R6: exactly the two high-half writes reached memory, with full words
        check(wr_count == 2, "R6 write count", 32'(wr_count), 2);
        check(mem[2] == 32'h6666_5555, "R6 word 2", mem[2], 32'h6666_5555);
        check(mem[4] == 32'h2222_1111, "R7 word 4", mem[4], 32'h2222_1111);

        // R11: selects latched at the address-strobe fall win over later pins
        @(negedge clk);
        host_reg_sel = 2'b10; host_rd_wr = 1'b1; host_half_sel = 1'b0;
        host_as_n = 1'b0;
        repeat (5) @(negedge clk);
        host_reg_sel = 2'b00; host_half_sel = 1'b1;
        host_cs_n = 1'b0;
        @(negedge clk);
        host_ds_a = 1'b0;
        repeat (6) @(negedge clk);
        check(host_data_out == 16'h0014, "R11 latched select", 32'(host_data_out), 32'h14);
        host_ds_a = 1'b1;
        repeat (6) @(negedge clk);
        host_as_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: both strobes low, or chip deselected, starts nothing
        host_reg_sel = 2'b00; host_rd_wr = 1'b1; host_half_sel = 1'b0;
        host_cs_n = 1'b0; host_ds_a = 1'b0; host_ds_b = 1'b0;
        repeat (6) @(negedge clk);
        check(host_data_oe == 1'b0, "R1 both strobes low", 32'(host_data_oe), 0);
        host_ds_a = 1'b1; host_ds_b = 1'b1;
        @(negedge clk);
        host_cs_n = 1'b1;
        @(negedge clk);
        host_ds_a = 1'b0;
        repeat (6) @(negedge clk);
        check(host_data_oe == 1'b0, "R1 deselected", 32'(host_data_oe), 0);
        host_ds_a = 1'b1;
        repeat (4) @(negedge clk);
        host_access(2'b00, 1'b1, 1'b0, 16'h0, 1'b1, rdv, bd, ba, oed, oea);
        check(oed == 1'b1, "R1 second strobe oe", 32'(oed), 1);
        check(rdv == 16'h1234, "R1 second strobe data", 32'(rdv), 32'h1234);

        // R3, R9, R12: slow write with the chip deselected and then reselected
        mem_lat = 20;
        host_access(2'b11, 1'b0, 1'b0, 16'hAAAA, 1'b0, rdv, bd, ba, oed, oea);
        @(negedge clk);
        host_reg_sel = 2'b11; host_rd_wr = 1'b0; host_half_sel = 1'b1; host_data_in = 16'hBBBB;
        host_cs_n = 1'b0;
        @(negedge clk);
        host_ds_a = 1'b0;
        repeat (6) @(negedge clk);
        host_ds_a = 1'b1;
        @(negedge clk);
        host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(host_busy == 1'b0, "R3 busy while deselected", 32'(host_busy), 0);
        check(mem_req == 1'b1, "R12 request pending", 32'(mem_req), 1);
        a0 = mem_addr;
        repeat (3) @(negedge clk);
        check(mem_req == 1'b1 && mem_addr == a0, "R12 request stable", mem_addr, a0);
        host_cs_n = 1'b0;
        @(negedge clk);
        check(host_busy == 1'b1, "R9 busy on reselect", 32'(host_busy), 1);
        wait_idle();
        check(host_busy == 1'b0, "R9 busy released", 32'(host_busy), 0);
        check(mem[5] == 32'hBBBB_AAAA, "R9 word 5", mem[5], 32'hBBBB_AAAA);
        host_cs_n = 1'b1;
        mem_lat = 3;
        repeat (4) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule